// File: doc/BRIEF.md
# Reservation Station Entry with Single-Bus Operand Capture

This block is one reservation station entry. An instruction is loaded into it at dispatch together with its operands. Each operand arrives in one of two forms. It may already carry its value, read from the register file. Otherwise it is latent: it carries the id of the functional unit that will produce the value and the tag that unit will broadcast with the result.

Every result bus is routed to the entry. A latent operand does not compare its tag against all of them. Its stored unit id steers a multiplexer onto the one bus that unit drives, and a single comparator checks that bus's tag. Once every used operand holds its value, the entry raises an issue request. It becomes free when the functional unit grants that request.

A parameter selects the kind of unit the entry serves, and the kind sets the operand count:

- integer: two register operands;
- memory: two register operands plus a displacement constant;
- multiply-accumulate: three register operands.

Top module: `rs_entry`

## Requirements
- R1: After reset the entry is free, with `busy_o` = 0 and `req_o` = 0.
- R2: `alloc_i` is accepted only while `busy_o` is 0, and `busy_o` is 1 from the next cycle. An `alloc_i` seen while busy is ignored: the opcode and operand outputs keep their values.
- R3: A used operand whose `alloc_have_i` bit is 1 stores its `alloc_val_i` slice at allocation and is ready at once.
- R4: A latent operand with unit id u watches bus u only. Bus u carries tag bits [u*TAG_W +: TAG_W] and data bits [u*DATA_W +: DATA_W]. In a cycle where `res_vld_i[u]` is 1 and that tag equals the stored tag, the operand stores the data and is ready from the next cycle.
- R5: A latent operand ignores a matching tag on any bus other than its own, and ignores a valid result on its own bus when the tag differs.
- R6: If the awaited result is on the selected bus in the same cycle the entry is allocated, the operand captures it in that cycle.
- R7: Once an operand is ready, later broadcasts do not change its value while the entry is held.
- R8: An operand slot whose `alloc_use_i` bit is 0 is always ready and outputs zero.
- R9: `req_o` is 1 exactly when the entry is busy and every operand slot is ready. `gnt_i` while `req_o` is 1 frees the entry in the next cycle. Without a grant the request holds.
- R10: The operand count follows `KIND`: integer 2, memory 2, multiply-accumulate 3. Only the memory kind stores `alloc_disp_i` and presents it on `iss_disp_o`; the other kinds drive zero there.
- R11: `iss_op_o` presents the opcode captured at allocation. Slot k of `iss_opnd_o` occupies bits [k*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate request |
| alloc_op_i | input | OP_W | Opcode to store |
| alloc_use_i | input | NOPS | Slot used mask |
| alloc_have_i | input | NOPS | Slot value already present |
| alloc_val_i | input | NOPS*DATA_W | Values from register read |
| alloc_unit_i | input | NOPS*UNIT_W | Producing unit id per slot |
| alloc_tag_i | input | NOPS*TAG_W | Awaited tag per slot |
| alloc_disp_i | input | DATA_W | Displacement (memory kind) |
| res_vld_i | input | NUM_BUS | Result bus valid flags |
| res_tag_i | input | NUM_BUS*TAG_W | Result bus tags |
| res_data_i | input | NUM_BUS*DATA_W | Result bus data |
| gnt_i | input | 1 | Functional unit accepts the entry |
| busy_o | output | 1 | Entry holds an instruction |
| req_o | output | 1 | Issue request |
| iss_op_o | output | OP_W | Opcode to issue |
| iss_opnd_o | output | NOPS*DATA_W | Operand values |
| iss_disp_o | output | DATA_W | Displacement or zero |

## Verification
The main instance uses the multiply-accumulate kind, three slots, four buses, 4-bit tags and 16-bit data. With that setup a single entry can have one operand present, one captured from its own bus and one captured in the allocation cycle, while decoy tags run on neighbouring buses. A second instance uses the memory kind with the same bus setup. It exercises the displacement path and the two-slot request condition.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {RS_INT, RS_MEM, RS_MAC} rs_kind_e;

  function automatic int kind_ops(rs_kind_e k);
    return (k == RS_MAC) ? 3 : 2;
  endfunction
endpackage

// File: rtl/rs_bus_pick.sv
module rs_bus_pick #(
  parameter int NUM_BUS = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 32,
  parameter int UNIT_W  = 2
) (
  input  logic [UNIT_W-1:0]         sel_i,
  input  logic [NUM_BUS-1:0]        vld_i,
  input  logic [NUM_BUS*TAG_W-1:0]  tag_i,
  input  logic [NUM_BUS*DATA_W-1:0] data_i,
  output logic                      vld_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic [DATA_W-1:0]         data_o
);
  always_comb begin
    vld_o  = 1'b0;
    tag_o  = '0;
    data_o = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (sel_i == UNIT_W'(b)) begin
        vld_o  = vld_i[b];
        tag_o  = tag_i[b*TAG_W +: TAG_W];
        data_o = data_i[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int NUM_BUS = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 32,
  parameter int UNIT_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ent_vld_i,
  input  logic                      take_i,
  input  logic                      use_i,
  input  logic                      have_i,
  input  logic [DATA_W-1:0]         val_i,
  input  logic [UNIT_W-1:0]         unit_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [NUM_BUS-1:0]        bus_vld_i,
  input  logic [NUM_BUS*TAG_W-1:0]  bus_tag_i,
  input  logic [NUM_BUS*DATA_W-1:0] bus_data_i,
  output logic                      rdy_o,
  output logic [DATA_W-1:0]         val_o
);
  logic [UNIT_W-1:0] unit_q, sel_unit;
  logic [TAG_W-1:0]  tag_q, sel_tag, pk_tag;
  logic [DATA_W-1:0] val_q, pk_data;
  logic              rdy_q, pk_vld, watching, hit;

  // Allocation cycle watches the incoming unit/tag so a same-cycle result is not lost
  assign sel_unit = take_i ? unit_i : unit_q;
  assign sel_tag  = take_i ? tag_i  : tag_q;
  assign watching = take_i ? (use_i && !have_i) : (ent_vld_i && !rdy_q);

  rs_bus_pick #(
    .NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W), .UNIT_W(UNIT_W)
  ) u_pick (
    .sel_i (sel_unit),
    .vld_i (bus_vld_i),
    .tag_i (bus_tag_i),
    .data_i(bus_data_i),
    .vld_o (pk_vld),
    .tag_o (pk_tag),
    .data_o(pk_data)
  );

  assign hit = watching && pk_vld && (pk_tag == sel_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= '0;
      tag_q  <= '0;
      rdy_q  <= 1'b0;
      val_q  <= '0;
    end else if (take_i) begin
      unit_q <= unit_i;
      tag_q  <= tag_i;
      rdy_q  <= !use_i || have_i || hit;
      if (!use_i)      val_q <= '0;
      else if (have_i) val_q <= val_i;
      else if (hit)    val_q <= pk_data;
      else             val_q <= '0;
    end else if (hit) begin
      rdy_q <= 1'b1;
      val_q <= pk_data;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && ent_vld_i && !rdy_q && pk_vld && pk_tag == tag_q)
      |=> (rdy_q && val_q == $past(pk_data)));

  assert_no_false_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && ent_vld_i && !rdy_q && !(pk_vld && pk_tag == tag_q)) |=> !rdy_q);

  assert_hold_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && ent_vld_i && rdy_q) |=> $stable(val_q));

  assert_unused_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !use_i) |=> (rdy_q && val_q == '0));
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter rs_kind_e KIND    = RS_MAC,
  parameter int       NUM_BUS = 4,
  parameter int       TAG_W   = 4,
  parameter int       DATA_W  = 32,
  parameter int       OP_W    = 8,
  localparam int      UNIT_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int      NOPS    = kind_ops(KIND)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  logic [OP_W-1:0]           alloc_op_i,
  input  logic [NOPS-1:0]           alloc_use_i,
  input  logic [NOPS-1:0]           alloc_have_i,
  input  logic [NOPS*DATA_W-1:0]    alloc_val_i,
  input  logic [NOPS*UNIT_W-1:0]    alloc_unit_i,
  input  logic [NOPS*TAG_W-1:0]     alloc_tag_i,
  input  logic [DATA_W-1:0]         alloc_disp_i,
  input  logic [NUM_BUS-1:0]        res_vld_i,
  input  logic [NUM_BUS*TAG_W-1:0]  res_tag_i,
  input  logic [NUM_BUS*DATA_W-1:0] res_data_i,
  input  logic                      gnt_i,
  output logic                      busy_o,
  output logic                      req_o,
  output logic [OP_W-1:0]           iss_op_o,
  output logic [NOPS*DATA_W-1:0]    iss_opnd_o,
  output logic [DATA_W-1:0]         iss_disp_o
);
  logic            valid_q, take, issue;
  logic [OP_W-1:0] op_q;
  logic [NOPS-1:0] rdy_vec;

  assign take  = alloc_i && !valid_q;
  assign issue = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      op_q    <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      op_q    <= alloc_op_i;
    end else if (issue) begin
      valid_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_opnd
    rs_operand #(
      .NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W), .UNIT_W(UNIT_W)
    ) u_opnd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ent_vld_i (valid_q),
      .take_i    (take),
      .use_i     (alloc_use_i[k]),
      .have_i    (alloc_have_i[k]),
      .val_i     (alloc_val_i[k*DATA_W +: DATA_W]),
      .unit_i    (alloc_unit_i[k*UNIT_W +: UNIT_W]),
      .tag_i     (alloc_tag_i[k*TAG_W +: TAG_W]),
      .bus_vld_i (res_vld_i),
      .bus_tag_i (res_tag_i),
      .bus_data_i(res_data_i),
      .rdy_o     (rdy_vec[k]),
      .val_o     (iss_opnd_o[k*DATA_W +: DATA_W])
    );
  end

  if (KIND == RS_MEM) begin : g_disp
    logic [DATA_W-1:0] disp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   disp_q <= '0;
      else if (take) disp_q <= alloc_disp_i;
    end
    assign iss_disp_o = disp_q;
  end else begin : g_no_disp
    logic unused_disp;
    assign unused_disp = ^alloc_disp_i;
    assign iss_disp_o  = '0;
  end

  assign busy_o   = valid_q;
  assign req_o    = valid_q && (&rdy_vec);
  assign iss_op_o = op_q;

  assert_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !busy_o) |=> busy_o);

  assert_ignore_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !gnt_i) |=> (busy_o && $stable(iss_op_o)));

  assert_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && !alloc_i) |=> !busy_o);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o);
endmodule

// File: tb/tb_rs_entry.sv
module tb_rs_entry;
  import rs_pkg::*;
  localparam int NB = 4, TW = 4, DW = 16, OW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          alloc = 0, alloc_m = 0, gnt = 0, gnt_m = 0;
  logic [OW-1:0] aop = '0;
  logic [2:0]    ause = '0, ahave = '0;
  logic [47:0]   aval = '0;
  logic [5:0]    aunit = '0;
  logic [11:0]   atag = '0;
  logic [15:0]   adisp = '0;
  logic [3:0]    bvld = '0;
  logic [15:0]   btag = '0;
  logic [63:0]   bdata = '0;

  logic busy, req, busy_m, req_m;
  logic [OW-1:0] iop, iop_m;
  logic [47:0]   opnd;
  logic [31:0]   opnd_m;
  logic [15:0]   disp, disp_m;

  rs_entry #(.KIND(RS_MAC), .NUM_BUS(NB), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .alloc_i(alloc), .alloc_op_i(aop),
    .alloc_use_i(ause), .alloc_have_i(ahave), .alloc_val_i(aval),
    .alloc_unit_i(aunit), .alloc_tag_i(atag), .alloc_disp_i(adisp),
    .res_vld_i(bvld), .res_tag_i(btag), .res_data_i(bdata), .gnt_i(gnt),
    .busy_o(busy), .req_o(req), .iss_op_o(iop), .iss_opnd_o(opnd), .iss_disp_o(disp));

  rs_entry #(.KIND(RS_MEM), .NUM_BUS(NB), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) dut_mem (
    .clk_i(clk), .rst_ni(rst_n), .alloc_i(alloc_m), .alloc_op_i(aop),
    .alloc_use_i(ause[1:0]), .alloc_have_i(ahave[1:0]), .alloc_val_i(aval[31:0]),
    .alloc_unit_i(aunit[3:0]), .alloc_tag_i(atag[7:0]), .alloc_disp_i(adisp),
    .res_vld_i(bvld), .res_tag_i(btag), .res_data_i(bdata), .gnt_i(gnt_m),
    .busy_o(busy_m), .req_o(req_m), .iss_op_o(iop_m), .iss_opnd_o(opnd_m), .iss_disp_o(disp_m));

  int checks = 0, errors = 0;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Behavioural reference of the three-slot entry
  bit          m_v, m_req, m_take, m_wait, m_hit;
  bit [2:0]    m_r;
  logic [15:0] m_val [3];
  int          m_unit [3];
  logic [3:0]  m_tag [3];
  logic [OW-1:0] m_op;
  int          u;
  logic [3:0]  t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v = 0; m_r = '0; m_op = '0;
      for (int k = 0; k < 3; k++) begin m_val[k] = '0; m_unit[k] = 0; m_tag[k] = '0; end
    end else begin
      m_req  = m_v && (&m_r);
      m_take = alloc && !m_v;
      for (int k = 0; k < 3; k++) begin
        u = m_take ? int'(aunit[k*2 +: 2]) : m_unit[k];
        t = m_take ? atag[k*4 +: 4] : m_tag[k];
        m_wait = m_take ? (ause[k] && !ahave[k]) : (m_v && !m_r[k]);
        m_hit  = m_wait && bvld[u] && (btag[u*4 +: 4] == t);
        if (m_take) begin
          m_unit[k] = u; m_tag[k] = t;
          if (!ause[k])      begin m_r[k] = 1; m_val[k] = '0; end
          else if (ahave[k]) begin m_r[k] = 1; m_val[k] = aval[k*16 +: 16]; end
          else if (m_hit)    begin m_r[k] = 1; m_val[k] = bdata[u*16 +: 16]; end
          else               begin m_r[k] = 0; m_val[k] = '0; end
        end else if (m_hit) begin
          m_r[k] = 1; m_val[k] = bdata[u*16 +: 16];
        end
      end
      if (m_take) begin m_v = 1; m_op = aop; end
      else if (m_req && gnt) m_v = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 model busy", 64'(busy), 64'(m_v));
    chk("R9 model req", 64'(req), 64'(m_v && (&m_r)));
    chk("R11 model op", 64'(iop), 64'(m_op));
    chk("R4 model operands", 64'(opnd), 64'({m_val[2], m_val[1], m_val[0]}));
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    alloc = 0; alloc_m = 0; gnt = 0; gnt_m = 0; bvld = '0; btag = '0; bdata = '0;
    ause = '0; ahave = '0; aval = '0; aunit = '0; atag = '0; adisp = '0; aop = '0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 busy", 64'(busy), 0);
    chk("R1 req", 64'(req), 0);

    // R3: all values present at allocation
    aop = 6'h15; ause = 3'b111; ahave = 3'b111; aval = {16'hcccc, 16'hbbbb, 16'haaaa}; alloc = 1;
    cyc(); idle();
    chk("R2 busy after alloc", 64'(busy), 1);
    chk("R9 req all ready", 64'(req), 1);
    chk("R3 operands", 64'(opnd), 64'h0000_cccc_bbbb_aaaa);
    chk("R11 opcode", 64'(iop), 64'h15);
    gnt = 1; cyc(); idle();
    chk("R9 freed by grant", 64'(busy), 0);

    // R4/R5: slot1 waits on unit 2 tag 7, slot2 on unit 1 tag 3
    aop = 6'h2a; ause = 3'b111; ahave = 3'b001; aval = {32'h0, 16'h1234};
    aunit = {2'd1, 2'd2, 2'd0}; atag = {4'd3, 4'd7, 4'd0}; alloc = 1;
    cyc(); idle();
    chk("R9 req low while waiting", 64'(req), 0);
    bvld = 4'b0111;
    btag = {4'd0, 4'd7, 4'd9, 4'd3};
    bdata = {16'h0, 16'h1111, 16'h2222, 16'h4444};
    cyc(); idle();
    chk("R4 slot1 captured from bus 2", 64'(opnd[31:16]), 64'h1111);
    chk("R5 slot2 ignores wrong bus and wrong tag", 64'(opnd[47:32]), 0);
    chk("R5 req still low", 64'(req), 0);
    bvld = 4'b0010; btag = {8'h0, 4'd3, 4'd0}; bdata = {32'h0, 16'h3333, 16'h0};
    cyc(); idle();
    chk("R4 slot2 captured from bus 1", 64'(opnd[47:32]), 64'h3333);
    chk("R9 req once all ready", 64'(req), 1);
    bvld = 4'b0110; btag = {4'd0, 4'd7, 4'd3, 4'd0}; bdata = {16'h0, 16'hdead, 16'hbeef, 16'h0};
    cyc(); idle();
    chk("R7 ready operands unchanged", 64'(opnd), 64'h0000_3333_1111_1234);
    aop = 6'h01; ause = 3'b111; ahave = 3'b111; aval = 48'h5555_6666_7777; alloc = 1;
    cyc(); idle();
    chk("R2 alloc ignored while busy opcode", 64'(iop), 64'h2a);
    chk("R2 alloc ignored while busy operands", 64'(opnd), 64'h0000_3333_1111_1234);
    chk("R9 req holds without grant", 64'(req), 1);
    gnt = 1; cyc(); idle();
    chk("R9 freed", 64'(busy), 0);

    // R6: result on bus 3 in the allocation cycle; R8 slot1 unused
    aop = 6'h07; ause = 3'b101; ahave = 3'b100; aval = {16'h0f0f, 32'h0};
    aunit = {2'd0, 2'd0, 2'd3}; atag = {8'h0, 4'd5}; alloc = 1;
    bvld = 4'b1000; btag = {4'd5, 12'h0}; bdata = {16'h5555, 48'h0};
    cyc(); idle();
    chk("R6 same-cycle capture", 64'(opnd[15:0]), 64'h5555);
    chk("R8 unused slot zero", 64'(opnd[31:16]), 0);
    chk("R6 req", 64'(req), 1);
    gnt = 1; cyc(); idle();

    // R8: no slot used
    aop = 6'h3f; ause = 3'b000; alloc = 1;
    cyc(); idle();
    chk("R8 no used slots ready", 64'(req), 1);
    gnt = 1; cyc(); idle();
    chk("R9 freed again", 64'(busy), 0);

    // R10: memory kind, two slots plus displacement
    aop = 6'h11; ause = 3'b011; ahave = 3'b011; aval = {16'h0, 16'h2222, 16'h1111};
    adisp = 16'h0abc; alloc_m = 1;
    cyc(); idle();
    chk("R10 mem req two slots", 64'(req_m), 1);
    chk("R10 mem displacement", 64'(disp_m), 64'h0abc);
    chk("R10 mem operands", 64'(opnd_m), 64'h2222_1111);
    chk("R10 mac displacement zero", 64'(disp), 0);
    gnt_m = 1; cyc(); idle();
    chk("R10 mem freed", 64'(busy_m), 0);

    cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule